// File: doc/BRIEF.md
# Dual-Slot Statically Scheduled Integer Core

This block is a small processor core that issues a fixed pair of 32-bit instructions every clock. Each cycle it fetches one 64-bit bundle from an instruction memory port. The upper word is the compute slot. It holds a register-register ALU operation, an add-immediate or a conditional branch. The lower word is the memory slot. It holds a word load or a word store. Both slots are decoded, read their operands and execute in the same cycle. The register file has four read ports and two write ports. The memory slot forms its address with its own adder, so it does not share the compute slot's ALU.

The hardware performs no hazard checks and never stalls. Ordering is entirely the job of the code generator. Compute results become visible to the next bundle. A load result is written one cycle later than a compute result, so the bundle immediately after a load still sees the old register value.

The instruction port is combinational: `imem_rdata` must hold the bundle at `imem_addr` in the same cycle. The data port is also plain, with no back-pressure. A store is committed at the clock edge that ends the cycle in which `dmem_we` is high. Read data must be presented on `dmem_rdata` during the cycle that follows `dmem_re`. Neither memory may ever delay the core, because the core has no way to wait.

Top module: `vliw_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0, `dmem_we` and `dmem_re` are 0, and every register reads 0 once reset is released.
- R2: The compute slot is bundle bits [63:32] and the memory slot is bits [31:0]. Without a taken branch, `imem_addr` rises by 8 every cycle.
- R3: In the compute slot, opcode 0x00 with funct 0x21/0x23/0x24/0x25/0x2A performs add, subtract, and, or, and signed set-less-than, writing rd. Opcode 0x08 writes rt with rs plus the sign-extended imm16, wrapping on overflow. These results are readable by the very next bundle.
- R4: In the compute slot, opcode 0x04 branches when rs equals rt and opcode 0x05 branches when they differ. A taken branch sets the next fetch to the branch address + 8 + (sign-extended imm16 × 8). The memory-slot instruction of the branch's own bundle still executes.
- R5: In the memory slot, opcode 0x2B (store) drives `dmem_we`, with `dmem_addr` = rs + sext(imm16) and `dmem_wdata` = rt in the same cycle. Opcode 0x23 (load) drives `dmem_re` with the same address, and writes the returned word into rt at the end of the following cycle.
- R6: A bundle issued right after a load reads the old value of the load's target register. The bundle two after the load reads the loaded value.
- R7: Neither slot sees the other slot's result from the same bundle. For example, a store in the memory slot reads its data register before the compute slot of that bundle writes it.
- R8: When a load result and a compute result target the same register in the same cycle, the load result is kept.
- R9: Writes to register 0 are discarded from both slots, and register 0 always reads 0.
- R10: Any opcode outside a slot's allowed set has no architectural effect: no register write, no memory access and no branch. This includes a memory opcode in the compute slot, a compute opcode in the memory slot, and the all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current bundle |
| imem_rdata | input | 64 | Bundle at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address from the memory slot |
| dmem_re | output | 1 | Load request; data expected next cycle |
| dmem_we | output | 1 | Store request, committed at this cycle's edge |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data for the request of the previous cycle |

## Verification
The hardest situation to reach from the ports is a load's delayed write colliding with a compute-slot write to the same register in the following bundle. Close behind it is the stale read of a load target in the very next bundle. Neither can be seen directly. So the stimulus program schedules a load and an add-immediate to one register in consecutive bundles, then stores that register two bundles later. The value that reaches data memory shows which write survived. The same pattern of "write in one bundle, store in a chosen later bundle" is used to expose the stale-read window, in-bundle independence and the skipped bundles after taken branches.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned IMM_W  = 16;

  localparam logic [5:0] OPC_SPECIAL = 6'h00;
  localparam logic [5:0] OPC_BEQ     = 6'h04;
  localparam logic [5:0] OPC_BNE     = 6'h05;
  localparam logic [5:0] OPC_ADDI    = 6'h08;
  localparam logic [5:0] OPC_LW      = 6'h23;
  localparam logic [5:0] OPC_SW      = 6'h2B;

  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic              wr_en;
    logic [RIDX_W-1:0] wr_reg;
    logic              use_imm;
    alu_op_e           op;
    logic              br_eq;
    logic              br_ne;
    logic              ld;
    logic              st;
    logic [RIDX_W-1:0] rs;
    logic [RIDX_W-1:0] rt;
    logic [IMM_W-1:0]  imm;
  } slot_dec_t;
endpackage

// File: rtl/vliw_slot_decode.sv
module vliw_slot_decode
  import vliw_pkg::*;
#(
  parameter int unsigned KIND = 0
) (
  input  logic [ILEN-1:0] insn,
  output slot_dec_t       dec
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic       unused_insn;

  assign opc = insn[31:26];
  assign fn  = insn[5:0];
  assign unused_insn = ^insn;

  always_comb begin
    dec         = '0;
    dec.op      = ALU_ADD;
    dec.rs      = insn[25:21];
    dec.rt      = insn[20:16];
    dec.imm     = insn[IMM_W-1:0];
    if (KIND == 0) begin
      unique case (opc)
        OPC_SPECIAL: begin
          dec.wr_reg = insn[15:11];
          dec.wr_en  = 1'b1;
          unique case (fn)
            FN_ADDU: dec.op = ALU_ADD;
            FN_SUBU: dec.op = ALU_SUB;
            FN_AND:  dec.op = ALU_AND;
            FN_OR:   dec.op = ALU_OR;
            FN_SLT:  dec.op = ALU_SLT;
            default: dec.wr_en = 1'b0;
          endcase
        end
        OPC_ADDI: begin
          dec.wr_en   = 1'b1;
          dec.wr_reg  = insn[20:16];
          dec.use_imm = 1'b1;
        end
        OPC_BEQ: dec.br_eq = 1'b1;
        OPC_BNE: dec.br_ne = 1'b1;
        default: ;
      endcase
    end else begin
      unique case (opc)
        OPC_LW:  dec.ld = 1'b1;
        OPC_SW:  dec.st = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 32,
  parameter int unsigned NRD  = 4,
  parameter int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr [NRD],
  output logic [XLEN-1:0] rd_data [NRD],
  input  logic            we0,
  input  logic [AW-1:0]   wa0,
  input  logic [XLEN-1:0] wd0,
  input  logic            we1,
  input  logic [AW-1:0]   wa1,
  input  logic [XLEN-1:0] wd1
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = (rd_addr[g] == '0) ? '0 : regs_q[rd_addr[g]];
  end

  // port 1 is written last so it wins a same-register collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      if (we0 && wa0 != '0) regs_q[wa0] <= wd0;
      if (we1 && wa1 != '0) regs_q[wa1] <= wd1;
    end
  end
endmodule

// File: rtl/vliw_alu.sv
module vliw_alu
  import vliw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/vliw_core.sv
module vliw_core
  import vliw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [2*ILEN-1:0] imem_rdata,
  output logic [XLEN-1:0]   dmem_addr,
  output logic              dmem_re,
  output logic              dmem_we,
  output logic [XLEN-1:0]   dmem_wdata,
  input  logic [XLEN-1:0]   dmem_rdata
);
  localparam int unsigned NSLOT   = 2;
  localparam int unsigned NREG    = 1 << RIDX_W;
  localparam int unsigned NRD     = 2 * NSLOT;
  localparam int unsigned BBYTES  = (NSLOT * ILEN) / 8;
  localparam int unsigned BSHIFT  = $clog2(BBYTES);

  logic [XLEN-1:0]   pc_q;
  logic [ILEN-1:0]   slot_word [NSLOT];
  slot_dec_t         dec [NSLOT];
  logic [RIDX_W-1:0] rf_ra [NRD];
  logic [XLEN-1:0]   rf_rd [NRD];
  logic [XLEN-1:0]   imm_ext [NSLOT];
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic              br_taken;
  logic [XLEN-1:0]   pc_seq;
  logic [XLEN-1:0]   pc_next;
  logic              ld_pend_q;
  logic [RIDX_W-1:0] ld_reg_q;
  logic              unused_dec;

  // slot 0 sits in the upper word of the bundle
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_word[s] = imem_rdata[(NSLOT-s)*ILEN-1 -: ILEN];
    vliw_slot_decode #(.KIND(s)) u_dec (
      .insn (slot_word[s]),
      .dec  (dec[s])
    );
    assign rf_ra[2*s]     = dec[s].rs;
    assign rf_ra[2*s + 1] = dec[s].rt;
    assign imm_ext[s] = {{(XLEN-IMM_W){dec[s].imm[IMM_W-1]}}, dec[s].imm};
  end

  assign unused_dec = ^{dec[0], dec[1]};

  vliw_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD), .AW(RIDX_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rf_ra),
    .rd_data (rf_rd),
    .we0     (dec[0].wr_en),
    .wa0     (dec[0].wr_reg),
    .wd0     (alu_y),
    .we1     (ld_pend_q),
    .wa1     (ld_reg_q),
    .wd1     (dmem_rdata)
  );

  // compute slot
  assign alu_b = dec[0].use_imm ? imm_ext[0] : rf_rd[1];

  vliw_alu #(.XLEN(XLEN)) u_alu (
    .a  (rf_rd[0]),
    .b  (alu_b),
    .op (dec[0].op),
    .y  (alu_y)
  );

  assign br_taken = (dec[0].br_eq && (rf_rd[0] == rf_rd[1])) ||
                    (dec[0].br_ne && (rf_rd[0] != rf_rd[1]));
  assign pc_seq   = pc_q + XLEN'(BBYTES);
  assign pc_next  = br_taken ? pc_seq + (imm_ext[0] << BSHIFT) : pc_seq;

  // memory slot with its own address adder
  assign dmem_addr  = rf_rd[2] + imm_ext[1];
  assign dmem_wdata = rf_rd[3];
  assign dmem_we    = rst_n && dec[1].st;
  assign dmem_re    = rst_n && dec[1].ld;
  assign imem_addr  = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      ld_pend_q <= 1'b0;
      ld_reg_q  <= '0;
    end else begin
      pc_q      <= pc_next;
      ld_pend_q <= dec[1].ld && (dec[1].rt != '0);
      ld_reg_q  <= dec[1].rt;
    end
  end
endmodule

// File: rtl/vliw_core_chk.sv
module vliw_core_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [63:0]     imem_rdata,
  input logic            dmem_re,
  input logic            dmem_we
);
  logic [5:0] op_s0;
  logic [5:0] op_s1;
  assign op_s0 = imem_rdata[63:58];
  assign op_s1 = imem_rdata[31:26];

  p_bundle_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[2:0] == 3'b000);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_s0 != 6'h04 && op_s0 != 6'h05) |=> imem_addr == $past(imem_addr) + XLEN'(8));

  p_store_from_slot1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> op_s1 == 6'h2B);

  p_load_from_slot1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |-> op_s1 == 6'h23);

  p_single_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));

  p_slot0_mem_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_s0 == 6'h2B && op_s1 != 6'h2B) |-> !dmem_we);
endmodule

bind vliw_core vliw_core_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_re    (dmem_re),
  .dmem_we    (dmem_we)
);

// File: tb/vliw_core_bench.sv
module vliw_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr;
  logic [63:0] imem_rdata;
  logic [31:0] dmem_addr;
  logic        dmem_re;
  logic        dmem_we;
  logic [31:0] dmem_wdata;
  logic [31:0] dmem_rdata;

  int checks = 0;
  int errors = 0;

  logic [63:0] prog [64];
  logic [31:0] ram  [64];
  logic [31:0] rdata_q;

  // reference model state
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;
  logic        mpend;
  logic [4:0]  mpreg;
  logic [31:0] mpval;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_core u_vliw_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = prog[imem_addr[8:3]];
  assign dmem_rdata = rdata_q;

  always @(posedge clk) begin
    if (dmem_we) ram[dmem_addr[7:2]] <= dmem_wdata;
    if (dmem_re) rdata_q <= ram[dmem_addr[7:2]];
  end

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input int imm);
    logic [31:0] v;
    v = imm;
    return {op, rs, rt, v[15:0]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_cycle();
    logic [31:0] s0, s1, imm0, imm1, a, b, res, addr, npc;
    logic        w0, taken, st, ld;
    logic [4:0]  dst;
    s0 = prog[mpc[8:3]][63:32];
    s1 = prog[mpc[8:3]][31:0];
    imm0 = {{16{s0[15]}}, s0[15:0]};
    imm1 = {{16{s1[15]}}, s1[15:0]};
    a = mreg[s0[25:21]];
    b = mreg[s0[20:16]];
    w0 = 1'b0; taken = 1'b0; dst = 5'd0; res = 32'd0;
    if (s0[31:26] == 6'h00) begin
      dst = s0[15:11];
      w0 = 1'b1;
      case (s0[5:0])
        6'h21: res = a + b;
        6'h23: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default: w0 = 1'b0;
      endcase
    end else if (s0[31:26] == 6'h08) begin
      w0 = 1'b1; dst = s0[20:16]; res = a + imm0;
    end else if (s0[31:26] == 6'h04) taken = (a == b);
    else if (s0[31:26] == 6'h05) taken = (a != b);
    st = (s1[31:26] == 6'h2B);
    ld = (s1[31:26] == 6'h23);
    addr = mreg[s1[25:21]] + imm1;
    npc = taken ? mpc + 32'd8 + (imm0 << 3) : mpc + 32'd8;

    // R2 / R4: fetch address; R5 / R10: memory port activity
    check(taken ? "R4" : "R2", "imem_addr", imem_addr, mpc);
    check("R10", "dmem_we", {31'd0, dmem_we}, {31'd0, st});
    check("R5", "dmem_re", {31'd0, dmem_re}, {31'd0, ld});
    if (st) begin
      check("R5", "store addr", dmem_addr, addr);
      check("R7", "store data", dmem_wdata, mreg[s1[20:16]]);
    end
    if (ld) check("R5", "load addr", dmem_addr, addr);

    // commit: compute write first, pending load last so it wins (R8, R9)
    if (w0 && dst != 5'd0) mreg[dst] = res;
    if (mpend && mpreg != 5'd0) mreg[mpreg] = mpval;
    mpend = ld;
    mpreg = s1[20:16];
    mpval = mmem[addr[7:2]];
    if (st) mmem[addr[7:2]] = mreg[s1[20:16]];
    mpc = npc;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      prog[i] = 64'd0;
      ram[i]  = 32'h1000 + 32'(i * 3);
      mmem[i] = 32'h1000 + 32'(i * 3);
    end
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mpc = 32'd0; mpend = 1'b0; mpreg = 5'd0; mpval = 32'd0;
    rdata_q = 32'd0;

    prog[0]  = {enc_i(6'h08, 5'd0, 5'd1, 5),        enc_i(6'h23, 5'd0, 5'd2, 4)};
    prog[1]  = {enc_r(6'h21, 5'd2, 5'd1, 5'd3),     enc_i(6'h2B, 5'd0, 5'd2, 64)};
    prog[2]  = {enc_r(6'h21, 5'd2, 5'd1, 5'd4),     enc_i(6'h2B, 5'd0, 5'd3, 68)};
    prog[3]  = {enc_i(6'h08, 5'd0, 5'd5, 7),        enc_i(6'h2B, 5'd0, 5'd5, 72)};
    prog[4]  = {enc_i(6'h08, 5'd0, 5'd6, 9),        enc_i(6'h23, 5'd0, 5'd6, 8)};
    prog[5]  = {enc_i(6'h08, 5'd0, 5'd6, 11),       enc_i(6'h23, 5'd0, 5'd7, 12)};
    prog[6]  = {enc_r(6'h23, 5'd4, 5'd1, 5'd8),     enc_i(6'h2B, 5'd0, 5'd6, 76)};
    prog[7]  = {enc_r(6'h2A, 5'd1, 5'd5, 5'd9),     enc_i(6'h2B, 5'd0, 5'd4, 80)};
    prog[8]  = {enc_i(6'h08, 5'd0, 5'd0, 33),       enc_i(6'h23, 5'd0, 5'd0, 0)};
    prog[9]  = {enc_r(6'h24, 5'd1, 5'd5, 5'd10),    32'd0};
    prog[10] = {enc_r(6'h25, 5'd1, 5'd5, 5'd11),    enc_i(6'h2B, 5'd0, 5'd0, 84)};
    prog[11] = {enc_i(6'h2B, 5'd0, 5'd1, 88),       enc_r(6'h21, 5'd1, 5'd1, 5'd12)};
    prog[12] = {32'd0,                              enc_i(6'h2B, 5'd0, 5'd12, 92)};
    prog[13] = {enc_i(6'h08, 5'd0, 5'd14, -1),      enc_i(6'h2B, 5'd0, 5'd8, 96)};
    prog[14] = {enc_r(6'h2A, 5'd14, 5'd1, 5'd15),   enc_i(6'h2B, 5'd0, 5'd9, 100)};
    prog[15] = {enc_i(6'h04, 5'd1, 5'd1, 2),        enc_i(6'h2B, 5'd0, 5'd10, 104)};
    prog[16] = {enc_i(6'h08, 5'd0, 5'd16, 1),       enc_i(6'h2B, 5'd0, 5'd11, 108)};
    prog[17] = {enc_i(6'h08, 5'd0, 5'd16, 1),       enc_i(6'h2B, 5'd0, 5'd11, 108)};
    prog[18] = {enc_i(6'h05, 5'd1, 5'd1, 5),        enc_i(6'h2B, 5'd0, 5'd15, 112)};
    prog[19] = {enc_i(6'h05, 5'd1, 5'd5, 1),        enc_i(6'h2B, 5'd0, 5'd7, 116)};
    prog[20] = {enc_i(6'h08, 5'd0, 5'd16, 1),       32'd0};
    prog[21] = {32'd0,                              enc_i(6'h2B, 5'd0, 5'd16, 120)};
    prog[22] = {enc_i(6'h04, 5'd0, 5'd0, -1),       32'd0};

    repeat (3) @(negedge clk);
    check("R1", "reset imem_addr", imem_addr, 32'd0);
    check("R1", "reset dmem_we", {31'd0, dmem_we}, 32'd0);
    check("R1", "reset dmem_re", {31'd0, dmem_re}, 32'd0);
    rst_n = 1'b1;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      #1;
      model_cycle();
      @(negedge clk);
    end

    check("R6", "stale load target stored", ram[16], 32'h0);
    check("R3", "forwarded add result", ram[17], 32'h5);
    check("R7", "in-bundle store sees old reg", ram[18], 32'h0);
    check("R8", "load wins write collision", ram[19], 32'h1006);
    check("R6", "loaded value two bundles on", ram[20], 32'h1008);
    check("R9", "register 0 stays zero", ram[21], 32'h0);
    check("R10", "store in compute slot ignored", ram[22], 32'h1042);
    check("R10", "compute op in memory slot ignored", ram[23], 32'h0);
    check("R3", "subtract result", ram[24], 32'h1003);
    check("R3", "slt true", ram[25], 32'h1);
    check("R4", "branch bundle memory slot done", ram[26], 32'h5);
    check("R4", "skipped bundles no store", ram[27], 32'h1051);
    check("R3", "signed slt of minus one", ram[28], 32'h1);
    check("R5", "load data via store", ram[29], 32'h1009);
    check("R1", "skipped write leaves reset zero", ram[30], 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule